// File: doc/BRIEF.md
# Write Status Polling Logic

This block sits in the read path of a byte-wide flash device. It sits between the array read port and the host read port. When no internal program or erase is running, a read returns the array byte unchanged. While an internal operation is busy, a read returns a status byte instead. The top status bit reports the inverted-data state. The bit below it flips on every read, so the host can poll until the operation completes. When the operation ends, the low six bits stay unreliable for a short settling window. During that window the top bit already shows true array data.

Read requests arrive on a valid/ready channel, and results leave on a second valid/ready channel. The array byte for a request is presented on `arr_data` in the same cycle as the request. The output stage holds one entry. A request is accepted when `rd_valid` and `rd_ready` are both high. `rd_ready` is high when the output entry is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response byte is held without change and no new request is taken. The busy flag, the operation type and the last programmed byte are plain level inputs. They come from the command logic. The status bits are valid from the cycle that logic raises `busy`, which it does after the final write of the command sequence.

Top module: `wsp_poll_top`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `rd_ready` is 1.
- R2: A read accepted while `busy` is low and no settling window is open returns `arr_data` unchanged, one cycle later on `rsp_data`.
- R3: A read accepted while `busy` is high and `op_erase` is 0 (program) returns bit 7 equal to the complement of `prog_byte[7]`.
- R4: A read accepted while `busy` is high and `op_erase` is 1 (erase) returns bit 7 equal to 0. Once the erase has finished, bit 7 follows the array, which reads 1 for an erased byte.
- R5: Bit 6 of successive status reads within one operation alternates 0,1,0,... Cycles without an accepted read do not advance it.
- R6: Bits 5..0 of a status read are 0.
- R7: For SETTLE_CYC cycles after `busy` falls, counting the falling cycle itself, an accepted read returns bit 7 equal to `arr_data[7]`. Bit 6 is frozen at the toggle state left by the operation, and bits 5..0 are 0.
- R8: After the settling window, reads return `arr_data` unchanged again.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_data` is stable, `rd_ready` is 0, and an offered read neither completes nor advances the toggle.
- R10: The start of each operation (a rising edge of `busy`) clears the toggle. The first status read of any operation therefore returns bit 6 = 0, whatever the previous operation left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy | input | 1 | High while an internal program or erase runs |
| op_erase | input | 1 | Operation type: 0 program, 1 erase |
| prog_byte | input | 8 | Byte being programmed |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted when high with `rd_valid` |
| arr_data | input | 8 | Array byte for the current request |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Consumer takes the response when high |
| rsp_data | output | 8 | Read result: array data or status |

## Verification
The assertions assume that `op_erase` and `prog_byte` hold steady while `busy` is high. They also assume that `arr_data` belongs to the request offered in the same cycle. The stimulus changes operation type and byte only while `busy` is low, and it drives `arr_data` together with every request. Consumer back-pressure is applied only in a dedicated phase, and the driver offers reads only where it can tell from `rd_ready` whether they are taken.

// File: rtl/wsp_pkg.sv
package wsp_pkg;
  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } wsp_op_e;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_STATUS = 2'd1,
    RD_SETTLE = 2'd2
  } wsp_rd_mode_e;
endpackage

// File: rtl/wsp_toggle.sv
module wsp_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic step,
  output logic tog_now
);
  logic tog_q;

  // a new operation sees a cleared toggle, even in its first cycle
  assign tog_now = start ? 1'b0 : tog_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       tog_q <= 1'b0;
    else if (start)   tog_q <= step;
    else if (step)    tog_q <= ~tog_q;
  end

  a_r5_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !start) |=> $stable(tog_q));
  a_r10_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !step) |=> (tog_q == 1'b0));
endmodule

// File: rtl/wsp_settle.sv
module wsp_settle #(
  parameter int SETTLE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic fall,
  output logic active
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  logic [CW-1:0] cnt_q;

  assign active = fall || (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (busy)            cnt_q <= '0;
    else if (fall)            cnt_q <= CW'(SETTLE_CYC - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  a_r7_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(SETTLE_CYC - 1));
  a_r7_busy_closes: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt_q == '0));
endmodule

// File: rtl/wsp_status_mux.sv
module wsp_status_mux
  import wsp_pkg::*;
#(
  parameter int W = 8
) (
  input  wsp_rd_mode_e  mode,
  input  wsp_op_e       op,
  input  logic [W-1:0]  prog_byte,
  input  logic [W-1:0]  arr_data,
  input  logic          tog,
  output logic [W-1:0]  data
);
  localparam int DP_BIT = W - 1;
  localparam int TG_BIT = W - 2;

  always_comb begin
    data = '0;
    unique case (mode)
      RD_STATUS: begin
        data[DP_BIT] = (op == OP_ERASE) ? 1'b0 : ~prog_byte[DP_BIT];
        data[TG_BIT] = tog;
      end
      RD_SETTLE: begin
        data[DP_BIT] = arr_data[DP_BIT];
        data[TG_BIT] = tog;
      end
      default: data = arr_data;
    endcase
  end
endmodule

// File: rtl/wsp_poll_top.sv
module wsp_poll_top
  import wsp_pkg::*;
#(
  parameter int W          = 8,
  parameter int SETTLE_CYC = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy,
  input  logic         op_erase,
  input  logic [W-1:0] prog_byte,
  input  logic         rd_valid,
  output logic         rd_ready,
  input  logic [W-1:0] arr_data,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [W-1:0] rsp_data
);
  localparam int DP_BIT = W - 1;
  localparam int TG_BIT = W - 2;

  logic         busy_q;
  logic         start, fall, rd_fire, tog_now, settling;
  wsp_rd_mode_e mode;
  logic [W-1:0] mux_data;

  assign start    = busy && !busy_q;
  assign fall     = !busy && busy_q;
  assign rd_ready = !rsp_valid || rsp_ready;
  assign rd_fire  = rd_valid && rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy;
  end

  wsp_toggle u_tog (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .step    (busy && rd_fire),
    .tog_now (tog_now)
  );

  wsp_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .fall   (fall),
    .active (settling)
  );

  always_comb begin
    if (busy)          mode = RD_STATUS;
    else if (settling) mode = RD_SETTLE;
    else               mode = RD_ARRAY;
  end

  wsp_status_mux #(.W(W)) u_mux (
    .mode      (mode),
    .op        (wsp_op_e'(op_erase)),
    .prog_byte (prog_byte),
    .arr_data  (arr_data),
    .tog       (tog_now),
    .data      (mux_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_fire || (rsp_valid && !rsp_ready);
      if (rd_fire) rsp_data <= mux_data;
    end
  end

  a_r3_prog_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && busy && !op_erase) |=> (rsp_data[DP_BIT] == !$past(prog_byte[DP_BIT])));
  a_r4_erase_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && busy && op_erase) |=> (rsp_data[DP_BIT] == 1'b0));
  a_r6_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && (busy || busy_q)) |=> (rsp_data[TG_BIT-1:0] == '0));
  a_r2_idle_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !busy && !settling) |=> (rsp_data == $past(arr_data)));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !rd_ready);
endmodule

// File: tb/wsp_poll_top_test.sv
module wsp_poll_top_test;
  localparam int ST = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       busy = 1'b0, op_erase = 1'b0, rd_valid = 1'b0, rsp_ready = 1'b1;
  logic [7:0] prog_byte = 8'h00, arr_data = 8'h00;
  logic       rd_ready, rsp_valid;
  logic [7:0] rsp_data;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  // bench model state
  logic m_tog = 1'b0, m_busy_prev = 1'b0;
  int   m_settle = 0;

  always #10 clk = ~clk;

  wsp_poll_top #(.W(8), .SETTLE_CYC(ST)) uut (
    .clk(clk), .rst_n(rst_n), .busy(busy), .op_erase(op_erase),
    .prog_byte(prog_byte), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .arr_data(arr_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one clock: drive inputs at negedge, predict, advance model after posedge
  task automatic step(input logic b, input logic rd, input logic [7:0] arr, input string tag);
    logic [7:0] e;
    logic acc;
    @(negedge clk);
    busy = b; rd_valid = rd; arr_data = arr;
    #1;
    acc = rd && rd_ready;
    if (b && !m_busy_prev) m_tog = 1'b0;
    if (!b && m_busy_prev) m_settle = ST;
    if (acc) begin
      if (b)                 e = {(op_erase ? 1'b0 : ~prog_byte[7]), m_tog, 6'b0};
      else if (m_settle > 0) e = {arr[7], m_tog, 6'b0};
      else                   e = arr;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      if (b) m_tog = ~m_tog;
    end
    @(posedge clk);
    if (!b && m_settle > 0) m_settle--;
    m_busy_prev = b;
  endtask

  // monitor: pops on each completed handshake
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) check(1'b0, "unexpected response", rsp_data, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rsp_data == e, t, rsp_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #5;
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
    check(rd_ready == 1'b1, "R1 rd_ready after reset", rd_ready, 1);

    // R2 idle pass-through
    step(0, 1, 8'hA5, "R2 idle read");
    step(0, 1, 8'h5A, "R2 idle read");
    step(0, 0, 8'h00, "");
    step(0, 1, 8'hFF, "R2 idle read");

    // program with bit7 = 1 -> status bit7 = 0
    op_erase = 1'b0; prog_byte = 8'h80;
    step(1, 0, 8'h11, "");
    step(1, 1, 8'h11, "R3 R5 R6 program status");
    step(1, 1, 8'h22, "R3 R5 R6 program status");
    step(1, 0, 8'h22, "");
    step(1, 0, 8'h22, "");
    step(1, 1, 8'h33, "R5 toggle not advanced by idle cycles");
    // fall and settle window (toggle now 1)
    for (int i = 0; i < ST; i++) step(0, 1, 8'hC3, "R7 settle window");
    step(0, 1, 8'h3C, "R8 after settle");
    step(0, 1, 8'h7E, "R8 after settle");

    // program with bit7 = 0, odd number of reads -> toggle left at 1
    prog_byte = 8'h3C;
    step(1, 1, 8'h00, "R3 R10 first status read");
    step(1, 1, 8'h00, "R3 R5 program status");
    step(1, 1, 8'h00, "R3 R5 program status");
    step(0, 0, 8'h00, "");
    // erase starting right after, first read in the rising cycle
    op_erase = 1'b1;
    step(1, 1, 8'h44, "R4 R10 erase first read clears toggle");
    step(1, 1, 8'h44, "R4 R5 erase status");

    // R9 back-pressure during busy
    @(negedge clk); rsp_ready = 1'b0;
    step(1, 1, 8'h44, "R4 R9 erase status under stall");
    #6;
    held = rsp_data;
    for (int i = 0; i < 3; i++) begin
      step(1, 1, 8'h44, "R9 must not complete");
      #6;
      check(rsp_valid && rsp_data == held, "R9 response held", rsp_data, held);
      check(rd_ready == 1'b0, "R9 rd_ready low while stalled", rd_ready, 0);
    end
    @(negedge clk); rsp_ready = 1'b1; rd_valid = 1'b0;
    @(posedge clk);
    step(1, 1, 8'h44, "R9 toggle not advanced by stalled reads");
    // erase done: erased array reads FF
    for (int i = 0; i < ST; i++) step(0, 1, 8'hFF, "R4 R7 erase settle bit7 one");
    step(0, 1, 8'hFF, "R4 R8 erased byte");
    step(0, 0, 8'h00, "");
    step(0, 0, 8'h00, "");
    repeat (3) @(posedge clk);
    check(exp_q.size() == 0, "all responses seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule